// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Slave

This block is the device side of a three-wire serial memory with 16-bit words. A host drives chip select, a serial clock and a data line. The block moves those three pins into its system clock domain and decodes each frame: a start bit, a two-bit opcode and an eight-bit address. Write frames then carry 16 data bits. It holds 256 words in plain registers. It answers reads on a data-out pin that carries its own output enable.

Writes are guarded in two ways. A write-enable latch must be set first, and it stays set until a disable command or reset. The moment chip select falls, measured in serial clock rises, then decides whether a write or write-all is dropped or committed. A committed write starts a timed internal cycle. During that cycle the block shows busy on data-out and ignores new frames.

Top module: `mw_eeprom_slave`

## Requirements
- R1: After reset data-out is not driven (`do_oe_o`=0) and the write-enable latch is clear.
- R2: Zeros clocked in while chip select is high and before the first 1 are ignored. That 1 is the start bit and is rise 1. The next two rises carry the opcode and the eight after that carry the address, MSB first. Opcode 10 is READ and opcode 01 is WRITE. Opcode 00 takes a sub-code from the top two address bits: 11 is enable, 00 is disable, 01 is write-all.
- R3: Enable and disable take effect at rise 11 and change no memory word. Data-out stays undriven for the whole frame.
- R4: WRITE and write-all frames change nothing while the latch is clear. READ works whatever the latch state.
- R5: READ drives a 0 after rise 11, then D15 to D0 after rises 12 to 27. If rises continue, the next word follows with no gap, and the address wraps from 255 to 0.
- R6: Dropping chip select at any point ends a read and releases data-out within 4 system clocks.
- R7: If chip select falls after fewer than 27 rises, a WRITE or write-all changes nothing.
- R8: If chip select falls after exactly 27 rises, the write commits. Rises 12 to 27 carry the data, MSB first.
- R9: If chip select falls after 28 or more rises, the write is cancelled.
- R10: A committed write-all loads every word with the data.
- R11: The internal cycle lasts `WRITE_CYCLES` system clocks. While chip select is high, data-out is driven 0 during the cycle and 1 after it. Frames sent during the cycle have no effect.
- R12: When a chip-select fall and a serial clock rise are seen in the same system clock, that rise is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, active high, asynchronous |
| sk_i | input | 1 | Serial clock, asynchronous |
| di_i | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out / ready status |
| do_oe_o | output | 1 | Output enable for do_o (0 = high impedance) |

## Verification
The hazard is a chip-select fall that lands in the same system clock as a serial clock rise. Here the rise count decides between abort and commit. The bench changes both pins in one time step, once on the 27th rise and once on the 28th. The reference model applies R12 and drops the coincident rise, so it expects the first frame to abort and the second to commit. The memory is then read back through a normal READ and the word is compared with the model.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_READ,
    CMD_WRITE,
    CMD_WRALL,
    CMD_DROP
  } cmd_e;

  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_EXT   = 2'b00;

  localparam logic [1:0] SUB_EN    = 2'b11;
  localparam logic [1:0] SUB_DIS   = 2'b00;
  localparam logic [1:0] SUB_WRALL = 2'b01;
endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] lvl_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], async_i[i]};
    end
    assign lvl_o[i] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/mw_array.sv
module mw_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              all_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[w] <= '0;
      else if (we_i && (all_i || wr_addr_i == ADDR_W'(w))) mem_q[w] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/mw_wtimer.sv
module mw_wtimer #(
  parameter int CYCLES = 1000,
  localparam int TW = $clog2(CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (start_i)       cnt_q <= TW'(CYCLES);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  // R11: a new cycle is never launched on top of a running one
  a_r11_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);
endmodule

// File: rtl/mw_frame.sv
module mw_frame
  import mw_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 16,
  parameter int HDR_BITS   = 11,
  parameter int FRAME_BITS = 27,
  parameter int CNT_W      = 5,
  localparam int SR_W  = (DATA_W - 1 > ADDR_W + 1) ? DATA_W - 1 : ADDR_W + 1,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              sk_i,
  input  logic              di_i,
  input  logic              busy_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_start_o,
  output logic              wr_all_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              do_o,
  output logic              do_oe_o
);
  logic              cs_prev_q, sk_prev_q;
  logic              sk_rise, cs_fall;
  logic              started_q, wel_q, status_q, do_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [SR_W-1:0]   sr_q;
  cmd_e              cmd_q;
  logic [ADDR_W-1:0] wr_addr_q, rd_addr_q;
  logic [DATA_W-1:0] wr_data_q, out_sr_q;
  logic [IDX_W-1:0]  rd_idx_q;

  logic [ADDR_W+1:0] hdr_now;
  logic [1:0]        op_now, sub_now;
  logic [ADDR_W-1:0] addr_now;
  logic [DATA_W-1:0] data_now;

  assign sk_rise  = sk_i & ~sk_prev_q;
  assign cs_fall  = cs_prev_q & ~cs_i;
  assign hdr_now  = {sr_q[ADDR_W:0], di_i};
  assign op_now   = hdr_now[ADDR_W+1:ADDR_W];
  assign addr_now = hdr_now[ADDR_W-1:0];
  assign sub_now  = addr_now[ADDR_W-1 -: 2];
  assign data_now = {sr_q[DATA_W-2:0], di_i};

  assign rd_addr_o = (cmd_q == CMD_READ) ? rd_addr_q + 1'b1 : addr_now;

  // commit only when chip select drops with exactly FRAME_BITS rises counted
  assign wr_start_o = cs_fall && started_q && cnt_q == CNT_W'(FRAME_BITS) &&
                      (cmd_q == CMD_WRITE || cmd_q == CMD_WRALL);
  assign wr_all_o   = (cmd_q == CMD_WRALL);
  assign wr_addr_o  = wr_addr_q;
  assign wr_data_o  = wr_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_prev_q <= 1'b0;
      sk_prev_q <= 1'b0;
    end else begin
      cs_prev_q <= cs_i;
      sk_prev_q <= sk_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q <= 1'b0;
      cnt_q     <= '0;
      sr_q      <= '0;
      cmd_q     <= CMD_NONE;
      wel_q     <= 1'b0;
      status_q  <= 1'b0;
      do_q      <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
      rd_addr_q <= '0;
      out_sr_q  <= '0;
      rd_idx_q  <= '0;
    end else begin
      if (wr_start_o) status_q <= 1'b1;
      if (!cs_i) begin
        started_q <= 1'b0;
        cnt_q     <= '0;
        cmd_q     <= CMD_NONE;
        do_q      <= 1'b0;
      end else if (sk_rise) begin
        if (!started_q) begin
          if (di_i && !busy_i) begin
            started_q <= 1'b1;
            cnt_q     <= CNT_W'(1);
            status_q  <= 1'b0;
          end
        end else begin
          if (cnt_q != CNT_W'(FRAME_BITS + 1)) cnt_q <= cnt_q + 1'b1;
          sr_q <= {sr_q[SR_W-2:0], di_i};
          if (cnt_q == CNT_W'(HDR_BITS - 1)) begin
            cmd_q <= CMD_DROP;
            unique case (op_now)
              OPC_READ: begin
                cmd_q     <= CMD_READ;
                rd_addr_q <= addr_now;
                out_sr_q  <= rd_data_i;
                rd_idx_q  <= '0;
                do_q      <= 1'b0;
              end
              OPC_WRITE: begin
                wr_addr_q <= addr_now;
                if (wel_q) cmd_q <= CMD_WRITE;
              end
              OPC_EXT: begin
                if (sub_now == SUB_EN)  wel_q <= 1'b1;
                if (sub_now == SUB_DIS) wel_q <= 1'b0;
                if (sub_now == SUB_WRALL && wel_q) cmd_q <= CMD_WRALL;
              end
              default: ;
            endcase
          end
          if (cnt_q == CNT_W'(FRAME_BITS - 1)) wr_data_q <= data_now;
          if (cmd_q == CMD_READ) begin
            do_q <= out_sr_q[DATA_W-1];
            if (rd_idx_q == IDX_W'(DATA_W - 1)) begin
              rd_addr_q <= rd_addr_q + 1'b1;
              out_sr_q  <= rd_data_i;
              rd_idx_q  <= '0;
            end else begin
              out_sr_q <= out_sr_q << 1;
              rd_idx_q <= rd_idx_q + 1'b1;
            end
          end
        end
      end
    end
  end

  assign do_oe_o = cs_i & (status_q | (cmd_q == CMD_READ));
  assign do_o    = status_q ? ~busy_i : do_q;

  // R3: the latch moves only on a counted serial clock rise inside a frame
  a_r3_wel_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(wel_q) |-> $past(sk_rise && cs_i));

  // R4: a commit requires the write-enable latch
  a_r4_commit_needs_wel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_start_o |-> wel_q);
endmodule

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave #(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 16,
  parameter int WRITE_CYCLES = 1000,
  parameter int SYNC_STAGES  = 2,
  localparam int HDR_BITS    = 3 + ADDR_W,
  localparam int FRAME_BITS  = HDR_BITS + DATA_W,
  localparam int CNT_W       = $clog2(FRAME_BITS + 2)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic do_o,
  output logic do_oe_o
);
  logic [2:0]        pins_s;
  logic              busy;
  logic              wr_start, wr_all;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data;

  mw_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({cs_i, sk_i, di_i}),
    .lvl_o   (pins_s)
  );

  mw_frame #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HDR_BITS(HDR_BITS),
    .FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)
  ) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_i       (pins_s[2]),
    .sk_i       (pins_s[1]),
    .di_i       (pins_s[0]),
    .busy_i     (busy),
    .rd_addr_o  (rd_addr),
    .rd_data_i  (rd_data),
    .wr_start_o (wr_start),
    .wr_all_o   (wr_all),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data),
    .do_o       (do_o),
    .do_oe_o    (do_oe_o)
  );

  mw_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (wr_start),
    .all_i     (wr_all),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data)
  );

  mw_wtimer #(.CYCLES(WRITE_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (wr_start),
    .busy_o  (busy)
  );

  // R8: a commit is only ever taken on a synchronized chip-select low
  a_r8_commit_cs_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_start |-> !pins_s[2]);

  // R11: busy starts the cycle after a commit
  a_r11_busy_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_start |=> busy);
endmodule

// File: tb/mw_eeprom_slave_tb.sv
module mw_eeprom_slave_tb;
  localparam int CLK_P = 10;
  localparam int HALF  = 6;
  localparam int WCYC  = 600;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic do_w, oe_w;

  int checks = 0, errors = 0;
  int mem_m [256];
  bit wel_m = 1'b0;
  int cs_low_cnt = 0;

  always #(CLK_P/2) clk = ~clk;

  mw_eeprom_slave #(.WRITE_CYCLES(WCYC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di),
    .do_o(do_w), .do_oe_o(oe_w)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // R6: with chip select low for 4+ clocks data-out must be released
  always @(negedge clk) begin
    if (rst_n) begin
      if (cs) cs_low_cnt = 0;
      else begin
        if (cs_low_cnt >= 4) chk(!oe_w, "R6", "oe with cs low", oe_w, 0);
        cs_low_cnt++;
      end
    end
  end

  task automatic bit_out(input logic b, output logic d, output logic oe);
    di = b;
    wclk(HALF);
    sk = 1'b1;
    wclk(HALF);
    d  = do_w;
    oe = oe_w;
    sk = 1'b0;
  endtask

  function automatic bit is_write(input logic [1:0] op, input logic [7:0] a);
    return op == 2'b01 || (op == 2'b00 && a[7:6] == 2'b01);
  endfunction

  // sends nrise bits; if coincide, the last rise and the cs fall share a step
  task automatic frame(input logic [1:0] op, input logic [7:0] a,
                       input logic [15:0] data, input int nrise,
                       input bit coincide, output bit any_oe, output bit commit);
    logic [26:0] f;
    logic d, oe;
    int eff;
    f = {1'b1, op, a, data};
    any_oe = 1'b0;
    cs = 1'b1;
    wclk(4);
    for (int i = 1; i <= nrise; i++) begin
      logic b;
      b = (i <= 27) ? f[27-i] : 1'b0;
      if (coincide && i == nrise) begin
        di = b;
        wclk(HALF);
        sk = 1'b1;
        cs = 1'b0;
        wclk(HALF);
        sk = 1'b0;
      end else begin
        bit_out(b, d, oe);
        if (oe) any_oe = 1'b1;
      end
    end
    if (!coincide) begin
      wclk(HALF);
      cs = 1'b0;
    end
    wclk(6);
    eff = coincide ? nrise - 1 : nrise;
    if (op == 2'b00 && eff >= 11 && a[7:6] == 2'b11) wel_m = 1'b1;
    if (op == 2'b00 && eff >= 11 && a[7:6] == 2'b00) wel_m = 1'b0;
    commit = wel_m && eff == 27 && is_write(op, a);
    if (commit) begin
      if (op == 2'b01) mem_m[a] = data;
      else for (int k = 0; k < 256; k++) mem_m[k] = data;
    end
  endtask

  // R11: status on data-out during and after the internal cycle
  task automatic finish_write(input bit intrude);
    bit x, c;
    cs = 1'b1;
    wclk(6);
    chk(oe_w && !do_w, "R11", "busy shown low", {oe_w, do_w}, 2);
    if (intrude) begin
      cs = 1'b0;
      wclk(4);
      frame(2'b01, 8'h33, 16'hFFFF, 27, 1'b0, x, c);
      if (c) mem_m[8'h33] = 0;  // frame during busy must have no effect
      cs = 1'b1;
      wclk(6);
      chk(oe_w && !do_w, "R11", "still busy after intrusion", {oe_w, do_w}, 2);
    end
    wclk(WCYC + 10);
    chk(oe_w && do_w, "R11", "ready shown high", {oe_w, do_w}, 3);
    cs = 1'b0;
    wclk(6);
  endtask

  task automatic rd(input logic [7:0] a, input int nwords, input int lead0,
                    input string req);
    logic d, oe;
    logic [10:0] h;
    bit early_oe;
    h = {1'b1, 2'b10, a};
    early_oe = 1'b0;
    cs = 1'b1;
    wclk(4);
    for (int i = 0; i < lead0; i++) bit_out(1'b0, d, oe);
    for (int i = 10; i >= 1; i--) begin
      bit_out(h[i], d, oe);
      if (oe) early_oe = 1'b1;
    end
    bit_out(h[0], d, oe);
    chk(!early_oe, "R2", "oe before address done", early_oe, 0);
    chk(oe && d == 1'b0, "R5", "dummy zero", {oe, d}, 2);
    for (int w = 0; w < nwords; w++) begin
      logic [15:0] word;
      int exp_w;
      word = '0;
      for (int b = 0; b < 16; b++) begin
        bit_out(1'b0, d, oe);
        word = {word[14:0], d};
      end
      exp_w = mem_m[(int'(a) + w) % 256];
      chk(word == 16'(exp_w), req, $sformatf("read word %0d at %0h", w,
          (int'(a) + w) % 256), word, exp_w);
    end
    cs = 1'b0;
    wclk(6);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    bit any_oe, c;
    logic d, oe;
    for (int k = 0; k < 256; k++) mem_m[k] = 0;
    wclk(5);
    rst_n = 1'b1;
    wclk(3);
    chk(!oe_w, "R1", "oe after reset", oe_w, 0);
    cs = 1'b1;
    wclk(6);
    chk(!oe_w, "R1", "oe idle cs high", oe_w, 0);
    cs = 1'b0;
    wclk(4);

    // R1/R4: latch clear after reset, write dropped, read still works
    frame(2'b01, 8'h05, 16'hA5A5, 27, 1'b0, any_oe, c);
    rd(8'h05, 1, 0, "R4");

    // R3: enable frame, no drive
    frame(2'b00, 8'hC0, 16'h0, 11, 1'b0, any_oe, c);
    chk(!any_oe, "R3", "oe during enable frame", any_oe, 0);

    // R8: commit with exactly 27 rises
    frame(2'b01, 8'h05, 16'h1234, 27, 1'b0, any_oe, c);
    chk(c, "R8", "model commit", c, 1);
    finish_write(1'b0);
    rd(8'h05, 1, 3, "R8");  // R2 leading zeros

    // R7: early fall aborts
    frame(2'b01, 8'h06, 16'hBEEF, 20, 1'b0, any_oe, c);
    rd(8'h06, 1, 0, "R7");
    // R9: extra rises cancel
    frame(2'b01, 8'h06, 16'hBEEF, 29, 1'b0, any_oe, c);
    cs = 1'b1;
    wclk(6);
    chk(!oe_w, "R9", "no busy after cancel", oe_w, 0);
    cs = 1'b0;
    wclk(6);
    rd(8'h06, 1, 0, "R9");

    // R12: fall coincident with rise 27 -> 26 counted -> abort
    frame(2'b01, 8'h07, 16'h7777, 27, 1'b1, any_oe, c);
    rd(8'h07, 1, 0, "R12");
    // R12: fall coincident with rise 28 -> 27 counted -> commit
    frame(2'b01, 8'h07, 16'h7777, 28, 1'b1, any_oe, c);
    chk(c, "R12", "model commit on 28th coincident", c, 1);
    finish_write(1'b1);
    rd(8'h07, 1, 0, "R12");
    rd(8'h33, 1, 0, "R11");

    // R6: abort a read mid-word
    cs = 1'b1;
    wclk(4);
    for (int i = 0; i < 15; i++) bit_out((i < 2) ? 1'b1 : 1'b0, d, oe);
    chk(oe, "R6", "read driving before abort", oe, 1);
    cs = 1'b0;
    wclk(4);
    chk(!oe_w, "R6", "released after abort", oe_w, 0);
    wclk(4);
    rd(8'h05, 1, 0, "R6");

    // R5: auto-increment over several words
    rd(8'h05, 3, 0, "R5");

    // R4: disable then write and write-all are dropped
    frame(2'b00, 8'h00, 16'h0, 11, 1'b0, any_oe, c);
    chk(!any_oe, "R3", "oe during disable frame", any_oe, 0);
    frame(2'b01, 8'h08, 16'h5555, 27, 1'b0, any_oe, c);
    rd(8'h08, 1, 0, "R4");
    frame(2'b00, 8'h40, 16'h9999, 27, 1'b0, any_oe, c);
    rd(8'h05, 1, 0, "R4");

    // R10: write-all, then read across the wrap
    frame(2'b00, 8'hC0, 16'h0, 11, 1'b0, any_oe, c);
    frame(2'b00, 8'h40, 16'hC3C3, 27, 1'b0, any_oe, c);
    chk(c, "R10", "model write-all commit", c, 1);
    finish_write(1'b0);
    rd(8'hFE, 3, 0, "R10");
    rd(8'h80, 1, 0, "R10");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule